// File: doc/BRIEF.md
# Module Control Register Pair with Self-Clearing Software Reset

This block holds the control bits of a bus slave behind a pair of write-one registers: one write port sets bits, the other clears them. Two bits are live. The module-enable flag gates whether the slave's main memory space may answer; while it is 0 only the configuration space responds. The software reset flag lets a driver reset the local logic behind the slave.

The block also merges three reset causes into one registered, active-low reset for that local logic. The three causes are a synchronous power-on reset, an asynchronous bus system reset and the software reset flag. The software reset flag does not stay set until software clears it. It drops by itself on the next write to either register of the pair. This keeps older drivers working, since they write the flag once and never clear it.

The register space is decoded outside the block. The block sees a write strobe, a one-bit register select and the write data. A read of either register returns the same live bit image.

Top module: `ctrl_regset`

## Requirements
- R1: While `por_i` is high and on the first cycle after it falls, `mod_en_o` is 0 and `rd_data_o` is 0x00.
- R2: A write to the set register (`sel_i`=0) with bit 4 of the data at 1 makes `mod_en_o` 1 from the next cycle. Writing 0x10 therefore enables the module.
- R3: A write to the clear register (`sel_i`=1) with bit 4 at 1 makes `mod_en_o` 0 from the next cycle.
- R4: A write to the set register with bit 7 at 1, made while the software reset flag is 0, sets the flag. `local_rst_n_o` is then low from the cycle after the flag is set.
- R5: Any write to either register, made while the software reset flag is 1, clears the flag. This holds even when the data has bit 7 at 1. The enable effect of that same write is still applied.
- R6: A write to the clear register with bit 7 at 1, made while the flag is 0, leaves the flag at 0.
- R7: `local_rst_n_o` is 0 on the cycle after any cycle in which `por_i` is high. A power-on reset also clears both control bits.
- R8: `sys_rst_i` passes through a two-flop synchroniser. After it rises, `local_rst_n_o` falls and both control bits clear at the third clock edge. After it falls, `local_rst_n_o` rises at the third clock edge.
- R9: `rd_data_o` shows the enable flag at bit 4 and the software reset flag at bit 7, with all other bits 0. Its value does not depend on `sel_i`.
- R10: When a write coincides with an active power-on reset or an active synchronised bus reset, the reset wins and the write has no effect.
- R11: Data bits other than 4 and 7 have no effect on either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high |
| sys_rst_i | input | 1 | Bus system reset, asynchronous, active high |
| wr_i | input | 1 | Register write strobe |
| sel_i | input | 1 | Register select: 0 = set register, 1 = clear register |
| wdata_i | input | 8 | Write data |
| mod_en_o | output | 1 | Module-enable flag |
| local_rst_n_o | output | 1 | Combined reset for local logic, active low, registered |
| rd_data_o | output | 8 | Read-back image of the control bits |

## Verification
Two functions can land on the same cycle: a register write and a hard reset (power-on, or the synchronised bus reset). The bench provokes this by holding the bus reset until it has crossed the synchroniser and then issuing a set-register write of 0x90. It also issues a write of 0x10 on the same cycle as a power-on reset. In both cases the bench expects both flags to read back 0 afterwards. A second collision happens inside the write path itself: a set of bit 7 arriving while the software reset flag is already set. The vector table judges it by expecting the flag to clear and the local reset to release one cycle later.

// File: rtl/ctrl_regset_pkg.sv
package ctrl_regset_pkg;

  typedef enum logic {
    SEL_SET = 1'b0,
    SEL_CLR = 1'b1
  } reg_sel_e;

endpackage

// File: rtl/ctrl_rst_sync.sv
module ctrl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic async_i,
  output logic sync_o
);

  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i) begin
        if (clr_i) chain_q <= '0;
        else       chain_q <= async_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i) begin
        if (clr_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ctrl_bits.sv
module ctrl_bits
  import ctrl_regset_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int EN_BIT  = 4,
  parameter int RST_BIT = 7
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_i,
  input  reg_sel_e          sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic              swrst_o,
  output logic [DATA_W-1:0] rd_o
);

  logic en_q;
  logic sw_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q <= 1'b0;
      sw_q <= 1'b0;
    end else if (wr_i) begin
      if (wdata_i[EN_BIT]) en_q <= (sel_i == SEL_SET);
      // Any write drops a pending soft reset; a fresh one needs a set write.
      sw_q <= !sw_q && (sel_i == SEL_SET) && wdata_i[RST_BIT];
    end
  end

  always_comb begin
    rd_o          = '0;
    rd_o[EN_BIT]  = en_q;
    rd_o[RST_BIT] = sw_q;
  end

  assign en_o    = en_q;
  assign swrst_o = sw_q;

  p_set_en_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i && sel_i == SEL_SET && wdata_i[EN_BIT] |=> en_q);

  p_clr_en_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i && sel_i == SEL_CLR && wdata_i[EN_BIT] |=> !en_q);

  p_self_clear_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i && sw_q |=> !sw_q);

  p_clr_no_swrst_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_i && sel_i == SEL_CLR && !sw_q |=> !sw_q);

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_i |=> $stable(en_q) && $stable(sw_q));

  p_reset_wins_r10: assert property (@(posedge clk_i)
    rst_i |=> !en_q && !sw_q);

endmodule

// File: rtl/ctrl_rst_combine.sv
module ctrl_rst_combine (
  input  logic clk_i,
  input  logic por_i,
  input  logic bus_rst_i,
  input  logic swrst_i,
  output logic rst_n_o
);

  logic rst_n_q;

  always_ff @(posedge clk_i) begin
    rst_n_q <= !(por_i || bus_rst_i || swrst_i);
  end

  assign rst_n_o = rst_n_q;

  p_por_low_r7: assert property (@(posedge clk_i)
    por_i |=> !rst_n_q);

  p_bus_low_r8: assert property (@(posedge clk_i) disable iff (por_i)
    bus_rst_i |=> !rst_n_q);

  p_swrst_low_r4: assert property (@(posedge clk_i) disable iff (por_i)
    swrst_i |=> !rst_n_q);

endmodule

// File: rtl/ctrl_regset.sv
module ctrl_regset
  import ctrl_regset_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int EN_BIT      = 4,
  parameter int RST_BIT     = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              sys_rst_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              mod_en_o,
  output logic              local_rst_n_o,
  output logic [DATA_W-1:0] rd_data_o
);

  logic     bus_rst_sync;
  logic     hard_rst;
  logic     swrst;
  reg_sel_e sel;

  assign sel      = reg_sel_e'(sel_i);
  assign hard_rst = por_i || bus_rst_sync;

  ctrl_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i   (clk_i),
    .clr_i   (por_i),
    .async_i (sys_rst_i),
    .sync_o  (bus_rst_sync)
  );

  ctrl_bits #(
    .DATA_W  (DATA_W),
    .EN_BIT  (EN_BIT),
    .RST_BIT (RST_BIT)
  ) u_bits (
    .clk_i   (clk_i),
    .rst_i   (hard_rst),
    .wr_i    (wr_i),
    .sel_i   (sel),
    .wdata_i (wdata_i),
    .en_o    (mod_en_o),
    .swrst_o (swrst),
    .rd_o    (rd_data_o)
  );

  ctrl_rst_combine u_comb (
    .clk_i     (clk_i),
    .por_i     (por_i),
    .bus_rst_i (bus_rst_sync),
    .swrst_i   (swrst),
    .rst_n_o   (local_rst_n_o)
  );

  p_por_clears_r7: assert property (@(posedge clk_i)
    por_i |=> !mod_en_o && rd_data_o == '0);

  p_rd_matches_r9: assert property (@(posedge clk_i) disable iff (por_i)
    rd_data_o[EN_BIT] == mod_en_o);

endmodule

// File: tb/ctrl_regset_bench.sv
module ctrl_regset_bench;

  logic       clk = 1'b0;
  logic       por_i = 1'b1;
  logic       sys_rst_i = 1'b0;
  logic       wr_i = 1'b0;
  logic       sel_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic       mod_en_o;
  logic       local_rst_n_o;
  logic [7:0] rd_data_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  ctrl_regset u_ctrl_regset (
    .clk_i         (clk),
    .por_i         (por_i),
    .sys_rst_i     (sys_rst_i),
    .wr_i          (wr_i),
    .sel_i         (sel_i),
    .wdata_i       (wdata_i),
    .mod_en_o      (mod_en_o),
    .local_rst_n_o (local_rst_n_o),
    .rd_data_o     (rd_data_o)
  );

  // {sel, data, expected enable, expected soft reset}
  localparam int NVEC = 10;
  localparam logic [10:0] VEC [NVEC] = '{
    {1'b0, 8'h10, 1'b1, 1'b0},  // R2 enable
    {1'b0, 8'h6F, 1'b1, 1'b0},  // R11 other bits ignored
    {1'b1, 8'h80, 1'b1, 1'b0},  // R6 clear of idle reset flag
    {1'b0, 8'h80, 1'b1, 1'b1},  // R4 soft reset set
    {1'b0, 8'h80, 1'b1, 1'b0},  // R5 self clear despite bit 7
    {1'b1, 8'h10, 1'b0, 1'b0},  // R3 disable
    {1'b0, 8'h90, 1'b1, 1'b1},  // R2 and R4 together
    {1'b1, 8'h10, 1'b0, 1'b0},  // R5 clear plus R3 applied
    {1'b1, 8'hFF, 1'b0, 1'b0},  // R6 / R11 all ones to clear
    {1'b0, 8'h10, 1'b1, 1'b0}   // R2 re-enable
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    tick();
    tick();
    check("R1 enable during por", 32'(mod_en_o), 32'd0);
    check("R1 readback during por", 32'(rd_data_o), 32'h00);
    check("R7 local reset during por", 32'(local_rst_n_o), 32'd0);
    por_i = 1'b0;
    check("R1 enable after por release", 32'(mod_en_o), 32'd0);
    tick();
    check("R7 local reset released", 32'(local_rst_n_o), 32'd1);

    for (int i = 0; i < NVEC; i++) begin
      sel_i   = VEC[i][10];
      wdata_i = VEC[i][9:2];
      wr_i    = 1'b1;
      tick();
      wr_i = 1'b0;
      tick();
      check($sformatf("R2/R3/R11 table step %0d enable", i), 32'(mod_en_o), 32'(VEC[i][1]));
      check($sformatf("R9 table step %0d readback", i), 32'(rd_data_o),
            32'({VEC[i][0], 2'b00, VEC[i][1], 4'b0000}));
      check($sformatf("R4/R5/R6 table step %0d local reset", i), 32'(local_rst_n_o),
            32'(!VEC[i][0]));
    end

    // R9: read image independent of select
    sel_i = 1'b1;
    tick();
    check("R9 readback clear select", 32'(rd_data_o), 32'h10);
    sel_i = 1'b0;
    tick();
    check("R9 readback set select", 32'(rd_data_o), 32'h10);

    // R8: bus reset through the synchroniser
    sys_rst_i = 1'b1;
    tick();
    check("R8 edge1 local reset", 32'(local_rst_n_o), 32'd1);
    tick();
    check("R8 edge2 local reset", 32'(local_rst_n_o), 32'd1);
    check("R8 edge2 enable", 32'(mod_en_o), 32'd1);
    tick();
    check("R8 edge3 local reset", 32'(local_rst_n_o), 32'd0);
    check("R8 edge3 enable", 32'(mod_en_o), 32'd0);

    // R10: write during synchronised bus reset
    sel_i   = 1'b0;
    wdata_i = 8'h90;
    wr_i    = 1'b1;
    tick();
    wr_i = 1'b0;
    check("R10 write under bus reset", 32'(rd_data_o), 32'h00);
    sys_rst_i = 1'b0;
    tick();
    tick();
    check("R8 release edge2 local reset", 32'(local_rst_n_o), 32'd0);
    tick();
    check("R8 release edge3 local reset", 32'(local_rst_n_o), 32'd1);

    // R10: write during power-on reset
    por_i   = 1'b1;
    wdata_i = 8'h10;
    wr_i    = 1'b1;
    tick();
    por_i = 1'b0;
    wr_i  = 1'b0;
    check("R10 write under por", 32'(mod_en_o), 32'd0);
    tick();

    // R7: por pulse clears enable and asserts local reset
    wdata_i = 8'h10;
    wr_i    = 1'b1;
    tick();
    wr_i = 1'b0;
    check("R2 enable before por pulse", 32'(mod_en_o), 32'd1);
    por_i = 1'b1;
    tick();
    por_i = 1'b0;
    check("R7 por pulse local reset", 32'(local_rst_n_o), 32'd0);
    check("R7 por pulse enable", 32'(mod_en_o), 32'd0);
    tick();
    check("R7 local reset after pulse", 32'(local_rst_n_o), 32'd1);

    done = 1'b1;
    finish_run();
  end

endmodule